// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Non-Overlap Timing

This block converts a speed-modulation input and a direction input into four gate-enable signals for a full H-bridge. The bridge has two legs, A and B. Each leg has one high-side switch and one low-side switch. In the forward direction current flows from leg A through the load to leg B. In the reverse direction it flows from leg B to leg A. While the modulation input is low, both low-side switches conduct so the load current recirculates (brake). A permanently high modulation input runs the load at full speed in either direction.

Every change of the modulation or direction input starts a non-overlap window. The window length is set by a cycle-count input. A switch that must turn off is released at once. A switch that must turn on waits until the window has expired. A fault input removes all gate drive without delay.

Both control inputs are resynchronised to the clock. Their edges are therefore seen two clock edges after they arrive, and the window is loaded on the third edge.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With the modulation input high and direction low (forward), the steady outputs are {hi_a,lo_a,hi_b,lo_b} = 1001.
- R2: With the modulation input high and direction high (reverse), the steady outputs are 0110.
- R3: With the modulation input low, the steady outputs are 0101 (both low sides on, both high sides off) for either direction.
- R4: The high-side and low-side outputs of one leg are never high in the same cycle.
- R5: Take the negedge on which an input changes and call the next rising edge e0. Outputs that must turn off are low after edge e2. Outputs that must turn on are still low after edge e(N+1) and are high after edge e(N+2). Here N is the dead-time input.
- R6: A dead-time input of 0 behaves as N = 1.
- R7: An input change during a running window reloads the full count. The turn-on then follows the timing of R5, measured from the later change.
- R8: A change of the direction input alone also starts the window. It drops the old switches after e2 and turns on the new ones after e(N+2).
- R9: A constant input level (including 100% duty) gives constant outputs, with no periodic off pulse.
- R10: While fault is high, all outputs are low at once, without waiting for a clock edge. Fault also clears the counter. Take the negedge on which fault is released and call the next rising edge e0. The outputs stay low through e(N-1) and reach their target after eN.
- R11: All outputs are low during reset. Take the negedge on which reset is released and call the next rising edge e0. The outputs stay low through e(N+1) and reach their target after e(N+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Speed modulation input, asynchronous |
| dir_i | input | 1 | Direction select, 0 forward, 1 reverse, asynchronous |
| fault_i | input | 1 | Fault or disable, forces all gates off |
| dead_cycles_i | input | DT_W | Non-overlap length in clock cycles (0 acts as 1) |
| gate_hi_a_o | output | 1 | Leg A high-side enable |
| gate_lo_a_o | output | 1 | Leg A low-side enable |
| gate_hi_b_o | output | 1 | Leg B high-side enable |
| gate_lo_b_o | output | 1 | Leg B low-side enable |

## Verification
The assertions check four properties on every cycle:
- leg exclusivity;
- the absence of any turn-on while the window is still running;
- the one-per-cycle countdown and its clearing by fault;
- the all-off hold in the cycle after fault is released.

Only the bench's scenarios can show the following:
- the exact edge on which each switch changes, counted from an input change through the synchronizer;
- the reload of the count on a mid-window change;
- the zero-length mapping;
- the steadiness of 100% duty;
- the direction decoding.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef struct packed {
    logic hi_a;
    logic lo_a;
    logic hi_b;
    logic lo_b;
  } gate_t;

  localparam gate_t GATES_OFF = '{hi_a: 1'b0, lo_a: 1'b0, hi_b: 1'b0, lo_b: 1'b0};

  function automatic gate_t bridge_target(input logic run, input logic rev);
    gate_t g;
    g = GATES_OFF;
    if (!run) begin
      g.lo_a = 1'b1;
      g.lo_b = 1'b1;
    end else if (!rev) begin
      g.hi_a = 1'b1;
      g.lo_b = 1'b1;
    end else begin
      g.hi_b = 1'b1;
      g.lo_a = 1'b1;
    end
    return g;
  endfunction
endpackage

// File: rtl/hb_rst_sync.sv
`timescale 1ns/1ps
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = async_i;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_deadtime.sv
`timescale 1ns/1ps
module hb_deadtime #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             release_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = (len_i == '0) ? CNT_W'(1) : len_i;
    cnt_d    = cnt_q;
    if (fault_i)           cnt_d = '0;
    else if (start_i)      cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Turn-on allowed on the edge where the last counted cycle ends.
  assign release_o = !fault_i && !start_i && (cnt_q <= CNT_W'(1));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !start_i && !fault_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_fault_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (cnt_q == '0));

  p_reload_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !fault_i) |=> (cnt_q != '0));
endmodule

// File: rtl/hb_gate_stage.sv
`timescale 1ns/1ps
module hb_gate_stage
  import hb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fault_i,
  input  logic  release_i,
  input  gate_t target_i,
  output gate_t gates_q
);
  gate_t gates_d;

  always_comb begin
    if (fault_i)        gates_d = GATES_OFF;
    else if (release_i) gates_d = target_i;
    else                gates_d = gate_t'(gates_q & target_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gates_q <= GATES_OFF;
    else        gates_q <= gates_d;
  end

  p_no_early_turn_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !release_i |=> ((gates_q & ~$past(gates_q)) == 4'b0000));
endmodule

// File: rtl/hbridge_gate_seq.sv
`timescale 1ns/1ps
module hbridge_gate_seq
  import hb_pkg::*;
#(
  parameter int DT_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_i,
  input  logic            dir_i,
  input  logic            fault_i,
  input  logic [DT_W-1:0] dead_cycles_i,
  output logic            gate_hi_a_o,
  output logic            gate_lo_a_o,
  output logic            gate_hi_b_o,
  output logic            gate_lo_b_o
);
  localparam int CTRL_W = 2;

  logic              rst_core_n;
  logic [CTRL_W-1:0] ctrl_s;
  logic [CTRL_W-1:0] ctrl_prev_q;
  logic              rearm_q;
  logic              rearm_d;
  logic              ctrl_edge;
  logic              start;
  logic              release_ok;
  gate_t             target;
  gate_t             gates_q;
  gate_t             gates_out;

  hb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  hb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i ({dir_i, pwm_i}),
    .sync_o  (ctrl_s)
  );

  // Edge detection on the synchronised controls; rearm forces a window after reset or fault.
  always_comb begin
    ctrl_edge = (ctrl_s != ctrl_prev_q);
    rearm_d   = fault_i;
    start     = ctrl_edge || rearm_q;
    target    = bridge_target(ctrl_s[0], ctrl_s[1]);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_prev_q <= '0;
      rearm_q     <= 1'b1;
    end else begin
      ctrl_prev_q <= ctrl_s;
      rearm_q     <= rearm_d;
    end
  end

  hb_deadtime #(.CNT_W(DT_W)) u_dead (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fault_i   (fault_i),
    .start_i   (start),
    .len_i     (dead_cycles_i),
    .release_o (release_ok)
  );

  hb_gate_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fault_i   (fault_i),
    .release_i (release_ok),
    .target_i  (target),
    .gates_q   (gates_q)
  );

  // Fault removes drive combinationally, ahead of the register stage.
  always_comb gates_out = fault_i ? GATES_OFF : gates_q;

  assign gate_hi_a_o = gates_out.hi_a;
  assign gate_lo_a_o = gates_out.lo_a;
  assign gate_hi_b_o = gates_out.hi_b;
  assign gate_lo_b_o = gates_out.lo_b;

  p_leg_a_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(gate_hi_a_o && gate_lo_a_o));

  p_leg_b_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(gate_hi_b_o && gate_lo_b_o));

  p_fault_release_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(fault_i) |=> (gates_q == GATES_OFF));

  p_steady_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (release_ok && $past(release_ok) && $stable(ctrl_s)) |=> $stable(gates_q));
endmodule

// File: tb/tb_hbridge_gate_seq.sv
`timescale 1ns/1ps
module tb_hbridge_gate_seq;
  localparam int DT_W = 10;
  localparam int NVEC = 6;
  // Entry: {pwm, dir, dead[9:0], expected {hi_a,lo_a,hi_b,lo_b}}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 10'd5,  4'b1001},
    {1'b1, 1'b1, 10'd3,  4'b0110},
    {1'b0, 1'b1, 10'd12, 4'b0101},
    {1'b1, 1'b0, 10'd0,  4'b1001},
    {1'b0, 1'b0, 10'd1,  4'b0101},
    {1'b1, 1'b1, 10'd7,  4'b0110}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0;
  logic dir = 1'b0;
  logic fault = 1'b0;
  logic [DT_W-1:0] dead = 10'd8;
  logic ha, la, hb, lb;
  int checks = 0;
  int errors = 0;
  int overlap = 0;

  always #4 clk = ~clk;

  hbridge_gate_seq #(.DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .dir_i(dir), .fault_i(fault),
    .dead_cycles_i(dead),
    .gate_hi_a_o(ha), .gate_lo_a_o(la), .gate_hi_b_o(hb), .gate_lo_b_o(lb)
  );

  function automatic logic [3:0] gates();
    return {ha, la, hb, lb};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(input logic p, input logic d, input logic [DT_W-1:0] n);
    @(negedge clk);
    pwm = p; dir = d; dead = n;
    wait_edges(int'(n) + 12);
  endtask

  // R4: leg exclusivity monitored every cycle.
  always @(negedge clk) if (rst_n && ((ha && la) || (hb && lb))) overlap++;

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: reset state and first window after release (N=8, brake target).
    #1 chk("R11 in reset", gates(), 4'b0000);
    wait_edges(3);
    chk("R11 in reset", gates(), 4'b0000);
    rst_n = 1'b1;
    wait_edges(10);
    chk("R11 hold after release", gates(), 4'b0000);
    wait_edges(1);
    chk("R11 on after window", gates(), 4'b0101);

    // R1 R2 R3 R6: steady decoding from the vector table.
    for (int i = 0; i < NVEC; i++) begin
      settle(VEC[i][15], VEC[i][14], VEC[i][13:4]);
      chk($sformatf("R1/R2/R3 vector %0d", i), gates(), VEC[i][3:0]);
    end

    // R5: forward to brake, N=8.
    settle(1'b1, 1'b0, 10'd8);
    pwm = 1'b0;
    wait_edges(3);
    chk("R5 turn-off at e2", gates(), 4'b0001);
    wait_edges(7);
    chk("R5 held through e(N+1)", gates(), 4'b0001);
    wait_edges(1);
    chk("R5 on after e(N+2)", gates(), 4'b0101);

    // R8: direction flip at full duty, reverse to forward.
    settle(1'b1, 1'b1, 10'd8);
    dir = 1'b0;
    wait_edges(3);
    chk("R8 old switches off", gates(), 4'b0000);
    wait_edges(7);
    chk("R8 held", gates(), 4'b0000);
    wait_edges(1);
    chk("R8 new switches on", gates(), 4'b1001);

    // R7: restart of the window by a second change.
    settle(1'b1, 1'b0, 10'd8);
    pwm = 1'b0;
    wait_edges(4);
    dir = 1'b1;
    wait_edges(10);
    chk("R7 window restarted", gates(), 4'b0001);
    wait_edges(1);
    chk("R7 on after restarted window", gates(), 4'b0101);

    // R6: zero length acts as one cycle.
    settle(1'b1, 1'b0, 10'd0);
    pwm = 1'b0;
    wait_edges(3);
    chk("R6 off at e2", gates(), 4'b0001);
    wait_edges(1);
    chk("R6 on after e3", gates(), 4'b0101);

    // R9: 100% duty in both directions, no off pulse.
    for (int d = 0; d < 2; d++) begin
      int bad;
      settle(1'b1, d[0], 10'd8);
      bad = 0;
      for (int c = 0; c < 200; c++) begin
        wait_edges(1);
        if (gates() !== (d == 0 ? 4'b1001 : 4'b0110)) bad++;
      end
      chk($sformatf("R9 full duty dir=%0d", d), 4'(bad), 4'd0);
    end

    // R10: fault takes effect at once and re-arms the window.
    settle(1'b1, 1'b0, 10'd8);
    fault = 1'b1;
    #1 chk("R10 immediate off", gates(), 4'b0000);
    wait_edges(2);
    chk("R10 off while held", gates(), 4'b0000);
    fault = 1'b0;
    wait_edges(8);
    chk("R10 hold after release", gates(), 4'b0000);
    wait_edges(1);
    chk("R10 on after window", gates(), 4'b1001);

    chk("R4 no leg overlap", 4'(overlap), 4'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule